// File: doc/BRIEF.md
# Start/Stop Reference Pulse Generator

This block produces two reference pulse trains, Start and Stop, from a single timebase clock. They are meant for exercising timing instruments such as event timers and interval counters. Two integer dividers are cascaded. The Stop divider counts timebase ticks, so a Stop boundary falls every N ticks (10 ns per tick at 100 MHz). The Start divider counts Stop boundaries, so Start is always locked to the Stop train. Three generation modes decide which boundaries actually emit a Stop pulse.

Five settings presets are held on chip. Each preset holds N, M and a mode. A front-panel button steps through the presets. A simple register-write port lets a host rewrite any field of any preset or pick a preset directly. Any change waits for the next Start boundary before it takes effect, so a period is never cut short. Status outputs show which preset and mode are currently in force, for driving an indicator.

Top module: `pulsegen_top`

## Requirements
- R1: Each pulse on `stopPulse` or `startPulse` lasts one clock cycle. Stop boundaries are spaced N clocks apart, and the first boundary after reset comes at the Nth rising edge.
- R2: The boundary at frame position 0 emits Start and Stop on the same cycle. In period and interval modes (codes 0 and 1) a frame is M Stop boundaries long.
- R3: In interval mode (code 1), the only Stop pulses are the one with each Start and the one a single Stop period after it.
- R4: In multi-stop mode (code 2), successive frames are 1, 2, 3 … M Stop periods long, then the sequence wraps to 1. Stop pulses occur only together with Start, so the k-th interval spans k Stop periods.
- R5: A stored N below 2 behaves as 2, and a stored M of 0 behaves as 1.
- R6: The button is synchronised by two flip-flops. It must stay high for DB_CYCLES consecutive clocks to count as a press. Each press advances the selected preset by one, wrapping from 4 to 0. Shorter glitches are ignored.
- R7: A host write (`wrEn`=1) to preset `wrIdx` with `wrField` 0 stores N from `wrData`, with 1 stores M from `wrData[7:0]`, and with 2 stores the mode from `wrData[1:0]`. A mode value of 3 is ignored.
- R8: `wrField`=3 selects preset `wrIdx` directly and takes priority over a button press on the same cycle. An index of 5 or more is ignored.
- R9: The selected preset, and any edit to it, take effect only at the next Start boundary.
- R10: After reset, preset i holds N=4+2i, M=2+i and mode i mod 3. Preset 0 is active, and both pulse outputs are low.
- R11: `statusIdx` and `statusMode` show the preset and mode in force. They change only on a Start cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock |
| rstN | input | 1 | Asynchronous reset, active low |
| btnRaw | input | 1 | Unsynchronised preset-step button, active high |
| wrEn | input | 1 | Host write strobe |
| wrIdx | input | 3 | Preset index for the write or select |
| wrField | input | 2 | 0 N, 1 M, 2 mode, 3 select preset |
| wrData | input | 16 | Write data |
| startPulse | output | 1 | One-cycle Start pulse |
| stopPulse | output | 1 | One-cycle Stop pulse |
| statusIdx | output | 3 | Preset in force |
| statusMode | output | 2 | Mode in force |

## Verification
Pulses are registered. A boundary decided at rising edge E is visible from E until E+1, and the status outputs update on that same edge. A host write lands at the edge that samples it, but a boundary at that very edge still uses the old settings. A button press lands DB_CYCLES+1 edges after the edge that first samples it high. The reference model in the bench counts edges since reset and schedules each Start and each Stop as an absolute edge number. Its predictions are compared with the outputs at every falling edge, half a cycle after the edge that produced them.

// File: rtl/pulsegen_pkg.sv
package pulsegen_pkg;
  localparam int PRESET_COUNT = 5;
  localparam int IDX_W = $clog2(PRESET_COUNT);
  localparam int N_W = 16;
  localparam int M_W = 8;
  localparam int DATA_W = 16;

  typedef enum logic [1:0] {
    MODE_PERIOD   = 2'd0,
    MODE_INTERVAL = 2'd1,
    MODE_MULTI    = 2'd2
  } genMode_e;

  // settings handed from control to datapath
  typedef struct packed {
    logic [IDX_W-1:0] idx;
    logic [N_W-1:0]   stopDiv;
    logic [M_W-1:0]   startDiv;
    genMode_e         mode;
  } presetCfg_t;

  function automatic logic [N_W-1:0] defStop(input int i);
    return N_W'(4 + 2 * i);
  endfunction

  function automatic logic [M_W-1:0] defStart(input int i);
    return M_W'(2 + i);
  endfunction

  function automatic genMode_e defMode(input int i);
    return genMode_e'(2'(i % 3));
  endfunction
endpackage

// File: rtl/pulsegen_ctrl.sv
module pulsegen_ctrl
  import pulsegen_pkg::*;
#(
  parameter int DB_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              btnRaw,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [1:0]        wrField,
  input  logic [DATA_W-1:0] wrData,
  output presetCfg_t        cfg
);
  localparam int CNT_W = $clog2(DB_CYCLES + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PRESET_COUNT - 1);

  logic [1:0]       syncQ;
  logic             btnSync, btnLevel, pressStb, hostSel, idxOk;
  logic [CNT_W-1:0] dbCnt;
  logic [IDX_W-1:0] selIdx;
  logic [N_W-1:0]   nArr [PRESET_COUNT];
  logic [M_W-1:0]   mArr [PRESET_COUNT];
  genMode_e         modeArr [PRESET_COUNT];

  assign btnSync  = syncQ[1];
  assign pressStb = btnSync && !btnLevel && (dbCnt == CNT_W'(DB_CYCLES - 1));
  assign idxOk    = wrIdx < IDX_W'(PRESET_COUNT);
  assign hostSel  = wrEn && (wrField == 2'd3) && idxOk;

  // two-stage synchroniser and level debouncer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ    <= '0;
      btnLevel <= 1'b0;
      dbCnt    <= '0;
    end else begin
      syncQ <= {syncQ[0], btnRaw};
      if (btnSync == btnLevel) dbCnt <= '0;
      else if (dbCnt == CNT_W'(DB_CYCLES - 1)) begin
        btnLevel <= btnSync;
        dbCnt    <= '0;
      end else dbCnt <= dbCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) selIdx <= '0;
    else if (hostSel) selIdx <= wrIdx;
    else if (pressStb) selIdx <= (selIdx == LAST_IDX) ? '0 : selIdx + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < PRESET_COUNT; i++) begin
        nArr[i]    <= defStop(i);
        mArr[i]    <= defStart(i);
        modeArr[i] <= defMode(i);
      end
    end else if (wrEn && idxOk) begin
      for (int i = 0; i < PRESET_COUNT; i++) begin
        if (wrIdx == IDX_W'(i)) begin
          case (wrField)
            2'd0: nArr[i] <= wrData[N_W-1:0];
            2'd1: mArr[i] <= wrData[M_W-1:0];
            2'd2: if (wrData[1:0] != 2'd3) modeArr[i] <= genMode_e'(wrData[1:0]);
            default: ;
          endcase
        end
      end
    end
  end

  assign cfg.idx      = selIdx;
  assign cfg.stopDiv  = nArr[selIdx];
  assign cfg.startDiv = mArr[selIdx];
  assign cfg.mode     = modeArr[selIdx];

  a_r6_single_step: assert property (@(posedge clk) disable iff (!rstN)
    (selIdx != $past(selIdx)) && !$past(hostSel) |->
      selIdx == (($past(selIdx) == LAST_IDX) ? IDX_W'(0) : $past(selIdx) + 1'b1));
  a_r8_index_range: assert property (@(posedge clk) disable iff (!rstN)
    selIdx < IDX_W'(PRESET_COUNT));
  a_r7_mode_legal: assert property (@(posedge clk) disable iff (!rstN)
    2'(cfg.mode) != 2'd3);
endmodule

// File: rtl/pulsegen_core.sv
module pulsegen_core
  import pulsegen_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  presetCfg_t       cfg,
  output logic             startPulse,
  output logic             stopPulse,
  output logic [IDX_W-1:0] actIdx,
  output genMode_e         actMode
);
  logic [N_W-1:0] tickCnt, actN, newN;
  logic [M_W-1:0] posCnt, frameLen, kLen, newM, kBase, kEff, newLen;
  logic           boundary, frameStart, stopNow;

  // clamped divisors and length of the frame that would start now
  always_comb begin
    newN   = (cfg.stopDiv < N_W'(2)) ? N_W'(2) : cfg.stopDiv;
    newM   = (cfg.startDiv == '0) ? M_W'(1) : cfg.startDiv;
    kBase  = (actMode == MODE_MULTI) ? kLen : M_W'(1);
    kEff   = (kBase > newM) ? M_W'(1) : kBase;
    newLen = (cfg.mode == MODE_MULTI) ? kEff : newM;
  end

  assign boundary   = (tickCnt == actN - 1'b1);
  assign frameStart = boundary && (posCnt == '0);
  assign stopNow    = (posCnt == '0) || (actMode == MODE_PERIOD) ||
                      ((actMode == MODE_INTERVAL) && (posCnt == M_W'(1)));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt    <= '0;
      actN       <= defStop(0);
      actIdx     <= '0;
      actMode    <= defMode(0);
      posCnt     <= '0;
      frameLen   <= M_W'(1);
      kLen       <= M_W'(1);
      startPulse <= 1'b0;
      stopPulse  <= 1'b0;
    end else begin
      startPulse <= 1'b0;
      stopPulse  <= 1'b0;
      if (boundary) begin
        tickCnt    <= '0;
        stopPulse  <= stopNow;
        startPulse <= frameStart;
        if (frameStart) begin
          actN     <= newN;
          actIdx   <= cfg.idx;
          actMode  <= cfg.mode;
          frameLen <= newLen;
          posCnt   <= (newLen == M_W'(1)) ? '0 : M_W'(1);
          if (cfg.mode == MODE_MULTI) kLen <= (kEff >= newM) ? M_W'(1) : kEff + 1'b1;
          else kLen <= M_W'(1);
        end else begin
          posCnt <= (posCnt == frameLen - 1'b1) ? '0 : posCnt + 1'b1;
        end
      end else begin
        tickCnt <= tickCnt + 1'b1;
      end
    end
  end

  a_r2_start_has_stop: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> stopPulse);
  a_r1_one_cycle_stop: assert property (@(posedge clk) disable iff (!rstN)
    stopPulse |=> !stopPulse);
  a_r9_status_held: assert property (@(posedge clk) disable iff (!rstN)
    !startPulse |-> $stable(actIdx) && $stable(actMode));
  a_r5_divisors_clamped: assert property (@(posedge clk) disable iff (!rstN)
    (actN >= N_W'(2)) && (frameLen >= M_W'(1)));
  a_r11_mode_legal: assert property (@(posedge clk) disable iff (!rstN)
    2'(actMode) != 2'd3);
endmodule

// File: rtl/pulsegen_top.sv
module pulsegen_top
  import pulsegen_pkg::*;
#(
  parameter int DB_CYCLES = 1000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        btnRaw,
  input  logic        wrEn,
  input  logic [2:0]  wrIdx,
  input  logic [1:0]  wrField,
  input  logic [15:0] wrData,
  output logic        startPulse,
  output logic        stopPulse,
  output logic [2:0]  statusIdx,
  output logic [1:0]  statusMode
);
  presetCfg_t cfg;
  genMode_e   actMode;

  pulsegen_ctrl #(.DB_CYCLES(DB_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .btnRaw(btnRaw), .wrEn(wrEn),
    .wrIdx(wrIdx), .wrField(wrField), .wrData(wrData), .cfg(cfg)
  );

  pulsegen_core u_core (
    .clk(clk), .rstN(rstN), .cfg(cfg),
    .startPulse(startPulse), .stopPulse(stopPulse),
    .actIdx(statusIdx), .actMode(actMode)
  );

  assign statusMode = 2'(actMode);
endmodule

// File: tb/tb_pulsegen_top.sv
module tb_pulsegen_top;
  localparam int DB = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic btnRaw = 1'b0;
  logic wrEn = 1'b0;
  logic [2:0] wrIdx = '0;
  logic [1:0] wrField = '0;
  logic [15:0] wrData = '0;
  logic startPulse, stopPulse;
  logic [2:0] statusIdx;
  logic [1:0] statusMode;

  pulsegen_top #(.DB_CYCLES(DB)) dut (
    .clk(clk), .rstN(rstN), .btnRaw(btnRaw), .wrEn(wrEn), .wrIdx(wrIdx),
    .wrField(wrField), .wrData(wrData), .startPulse(startPulse),
    .stopPulse(stopPulse), .statusIdx(statusIdx), .statusMode(statusMode)
  );

  always #10 clk = ~clk;

  int vectors = 0;
  int errors = 0;
  bit finished = 0;
  string phaseTag = "R10";

  // behavioural reference: absolute edge schedule
  int edgeNo = 0;
  int pN[5], pM[5], pMode[5];
  int sel = 0, aIdx = 0, aMode = 0, mk = 1;
  int nextStart = 4;
  int stopQ[$];
  int runLen = 0, advAt = -1;
  bit eStart = 0, eStop = 0;

  initial begin
    for (int i = 0; i < 5; i++) begin
      pN[i] = 4 + 2 * i;
      pM[i] = 2 + i;
      pMode[i] = i % 3;
    end
  end

  always @(posedge clk) begin
    if (rstN) begin
      int n, m, len, k;
      edgeNo++;
      eStart = 0;
      eStop = 0;
      if (edgeNo == nextStart) begin
        eStart = 1;
        eStop = 1;
        n = (pN[sel] < 2) ? 2 : pN[sel];
        m = (pM[sel] < 1) ? 1 : pM[sel];
        if (pMode[sel] == 2) begin
          k = (aMode == 2) ? mk : 1;
          if (k > m) k = 1;
          len = k;
          mk = (k >= m) ? 1 : k + 1;
        end else begin
          len = m;
          mk = 1;
        end
        aMode = pMode[sel];
        aIdx = sel;
        stopQ.delete();
        for (int j = 1; j < len; j++)
          if (aMode == 0 || (aMode == 1 && j == 1)) stopQ.push_back(edgeNo + j * n);
        nextStart = edgeNo + len * n;
      end else if (stopQ.size() > 0 && stopQ[0] == edgeNo) begin
        eStop = 1;
        void'(stopQ.pop_front());
      end
      // button: DB consecutive high samples, lands two edges later
      if (btnRaw) runLen++;
      else runLen = 0;
      if (runLen == DB) advAt = edgeNo + 2;
      if (edgeNo == advAt) sel = (sel + 1) % 5;
      if (wrEn && wrIdx < 5) begin
        case (wrField)
          2'd0: pN[wrIdx] = wrData;
          2'd1: pM[wrIdx] = wrData[7:0];
          2'd2: if (wrData[1:0] != 2'd3) pMode[wrIdx] = wrData[1:0];
          default: sel = wrIdx;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      vectors++;
      if (startPulse !== eStart) begin
        errors++;
        $display("FAIL R2 (%s) edge %0d startPulse=%b expected %b", phaseTag, edgeNo, startPulse, eStart);
      end
      if (stopPulse !== eStop) begin
        errors++;
        $display("FAIL %s edge %0d stopPulse=%b expected %b", phaseTag, edgeNo, stopPulse, eStop);
      end
      if (statusIdx !== 3'(aIdx) || statusMode !== 2'(aMode)) begin
        errors++;
        $display("FAIL R11 (%s) edge %0d status=%0d/%0d expected %0d/%0d",
                 phaseTag, edgeNo, statusIdx, statusMode, aIdx, aMode);
      end
    end
  end

  task automatic hostWrite(input int idx, input int field, input int data);
    @(negedge clk);
    wrEn = 1'b1;
    wrIdx = 3'(idx);
    wrField = 2'(field);
    wrData = 16'(data);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic holdButton(input int cycles);
    @(negedge clk);
    btnRaw = 1'b1;
    repeat (cycles) @(negedge clk);
    btnRaw = 1'b0;
    repeat (DB + 6) @(negedge clk);
  endtask

  task automatic idle(input int cycles);
    repeat (cycles) @(negedge clk);
  endtask

  initial begin
    phaseTag = "R10";
    idle(3);
    rstN = 1'b1;
    phaseTag = "R1";
    idle(30);
    phaseTag = "R9";
    hostWrite(0, 0, 5);
    idle(40);
    phaseTag = "R5";
    hostWrite(0, 0, 0);
    hostWrite(0, 1, 0);
    idle(30);
    phaseTag = "R6";
    holdButton(DB + 6);
    phaseTag = "R3";
    idle(60);
    phaseTag = "R7";
    hostWrite(1, 2, 3);
    idle(40);
    phaseTag = "R6";
    holdButton(DB - 3);
    idle(30);
    phaseTag = "R8";
    hostWrite(7, 3, 0);
    hostWrite(2, 3, 0);
    phaseTag = "R4";
    idle(260);
    phaseTag = "R8";
    hostWrite(4, 3, 0);
    idle(80);
    phaseTag = "R6";
    holdButton(DB + 4);
    idle(60);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog expired, actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule